// File: doc/BRIEF.md
# Machine CSR and Trap Unit

This block keeps the machine-level control and status registers of a small 32-bit core that has only two privilege levels, machine and user. The execute stage sends it one register access per cycle (write, set bits or clear bits, with a register source or a 5-bit immediate), and it answers at once with the old register value and an illegal flag. The new value is written at the next clock edge.

The pipeline raises a trap request when it takes an exception or an interrupt. The block records the return address, cause and faulting address, and updates the interrupt-enable stack and the privilege level. In the same cycle it gives the pipeline a redirect address taken from the trap-vector register, in either direct or vectored dispatch. A return strobe undoes the trap and redirects to the saved return address. Three pending-interrupt lines go through the enable mask, and the block reports whether an interrupt should be taken and which cause wins.

Registers are selected by a compact index from 0 to 12: vendor id (0), architecture id (1), implementation id (2), status (3), ISA word (4), interrupt enable (5), trap vector (6), status-high (7), return address (8), cause (9), trap value (10), interrupt pending (11), scratch (12).

Top module: `mcsr_trap_unit`

## Requirements
- R1: After reset the level is machine (2'b11), status reads 0, the trap vector reads the parameter RESET_TVEC, and no redirect, illegal flag or interrupt-take is asserted.
- R2: Indices 0, 1, 2 and 7 always read 0, index 4 reads the parameter ISA_WORD (default 32'h4000_1100: 32-bit base with integer and multiply/divide). An index of 13 or above is illegal.
- R3: acc_kind 2'b01 writes the source, 2'b10 ORs it in, 2'b11 clears its set bits, and 2'b00 is illegal. acc_rdata shows the value before the write, and with acc_use_imm=1 the source is acc_uimm zero-extended.
- R4: A set or clear whose source is zero writes nothing and is legal on any index. Any other write to a read-only index (0, 1, 2, 4, 11) is illegal and changes nothing.
- R5: Any register access while in user level (2'b00) is illegal and changes no register.
- R6: Legalised fields. Status keeps only the global enable (bit 3), the prior enable (bit 7) and the prior level (bits 12:11), and a written prior level other than 2'b11 becomes 2'b00. Interrupt enable keeps bits 3, 7 and 11. Trap-vector mode bits 1:0 keep 2'b01 (vectored), and every other mode becomes 2'b00 (direct). Return address bits 1:0 are forced to 0.
- R7: A trap stores trap_pc (word-aligned) as the return address and {trap_is_irq, zeros, trap_code} as the cause. It copies the global enable to the prior enable, clears the global enable, stores the current level as the prior level and enters machine level.
- R8: On an exception with code 0, 1, 4, 5, 6 or 7 the trap value captures trap_tval. Every other trap clears it to 0.
- R9: redirect_valid rises in the same cycle as trap_req. The target is the vector base (bits 31:2), plus 4*trap_code only for an interrupt in vectored mode.
- R10: A return in machine level redirects to the return address. Then the level becomes the prior level, the global enable takes the prior enable, the prior enable becomes 1 and the prior level becomes user. A return in user level is illegal, gives no redirect and changes nothing.
- R11: The pending word shows irq_in[0], irq_in[1] and irq_in[2] at bits 3, 7 and 11. irq_take is set when a pending and enabled line exists and the level is user or the global enable is set. irq_cause picks 11 first, then 3, then 7.
- R12: A trap request wins over a return and over a register write in the same cycle. Any return request also suppresses a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request |
| acc_kind | input | 2 | Access kind: 01 write, 10 set, 11 clear |
| acc_idx | input | 4 | Compact register index |
| acc_use_imm | input | 1 | Use the immediate source |
| acc_src | input | 32 | Register source |
| acc_uimm | input | 5 | Immediate source |
| acc_rdata | output | 32 | Old value of the selected register |
| illegal | output | 1 | Illegal access or illegal return |
| trap_req | input | 1 | Take a trap this cycle |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_code | input | 5 | Exception or interrupt code |
| trap_pc | input | 32 | Address of the trapping instruction |
| trap_tval | input | 32 | Faulting address |
| ret_req | input | 1 | Return-from-trap strobe |
| irq_in | input | 3 | Pending lines: software, timer, external |
| irq_take | output | 1 | An enabled interrupt is pending |
| irq_cause | output | 5 | Code of the winning interrupt |
| redirect_valid | output | 1 | Redirect the fetch this cycle |
| redirect_pc | output | 32 | Redirect target |
| priv_mode | output | 2 | Current privilege level |

## Verification
The bench builds the block with its default parameters. RESET_TVEC of 32'h100 makes the reset value of the vector register differ from a cleared register, and a stride of 4 keeps vectored targets on word boundaries that the bench can compute from the cause code. The table exercises each access kind and every legalised field. The directed part moves the level from machine to user and back through traps and returns. It also covers interrupt priority and masking, and drives trap, return and access requests in the same cycle.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned CODE_W  = 5;
  localparam int unsigned NUM_CSR = 13;
  localparam int unsigned IDX_W   = $clog2(NUM_CSR);
  localparam int unsigned NUM_IRQ = 3;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_SET   = 2'b10,
    KIND_CLEAR = 2'b11
  } acc_kind_e;

  localparam logic [1:0] PRIV_USER = 2'b00;
  localparam logic [1:0] PRIV_MACH = 2'b11;

  localparam logic [IDX_W-1:0] IX_VENDOR  = 4'd0;
  localparam logic [IDX_W-1:0] IX_ARCH    = 4'd1;
  localparam logic [IDX_W-1:0] IX_IMPL    = 4'd2;
  localparam logic [IDX_W-1:0] IX_STATUS  = 4'd3;
  localparam logic [IDX_W-1:0] IX_ISA     = 4'd4;
  localparam logic [IDX_W-1:0] IX_IE      = 4'd5;
  localparam logic [IDX_W-1:0] IX_TVEC    = 4'd6;
  localparam logic [IDX_W-1:0] IX_STATUSH = 4'd7;
  localparam logic [IDX_W-1:0] IX_EPC     = 4'd8;
  localparam logic [IDX_W-1:0] IX_CAUSE   = 4'd9;
  localparam logic [IDX_W-1:0] IX_TVAL    = 4'd10;
  localparam logic [IDX_W-1:0] IX_IP      = 4'd11;
  localparam logic [IDX_W-1:0] IX_SCRATCH = 4'd12;

  // status field positions
  localparam int unsigned BIT_GIE  = 3;
  localparam int unsigned BIT_PGIE = 7;
  localparam int unsigned BIT_PPL  = 11;

  // interrupt line positions (code equals bit position)
  localparam int unsigned BIT_SOFT  = 3;
  localparam int unsigned BIT_TIMER = 7;
  localparam int unsigned BIT_EXT   = 11;

  localparam logic [XLEN-1:0] IE_MASK =
    (XLEN'(1) << BIT_SOFT) | (XLEN'(1) << BIT_TIMER) | (XLEN'(1) << BIT_EXT);

  function automatic logic [XLEN-1:0] apply_op(input acc_kind_e k,
                                               input logic [XLEN-1:0] old_v,
                                               input logic [XLEN-1:0] src);
    case (k)
      KIND_WRITE: return src;
      KIND_SET:   return old_v | src;
      KIND_CLEAR: return old_v & ~src;
      default:    return old_v;
    endcase
  endfunction

  function automatic logic is_read_only(input logic [IDX_W-1:0] ix);
    return (ix == IX_VENDOR) || (ix == IX_ARCH) || (ix == IX_IMPL) ||
           (ix == IX_ISA) || (ix == IX_IP);
  endfunction

  function automatic logic tval_kept(input logic [CODE_W-1:0] c);
    return (c == 5'd0) || (c == 5'd1) || (c == 5'd4) ||
           (c == 5'd5) || (c == 5'd6) || (c == 5'd7);
  endfunction

  function automatic logic [XLEN-1:0] vec_target(input logic [XLEN-1:0] tvec,
                                                 input logic is_irq,
                                                 input logic [CODE_W-1:0] code,
                                                 input int unsigned sh);
    logic [XLEN-1:0] base;
    base = {tvec[XLEN-1:2], 2'b00};
    if (tvec[1:0] == 2'b01 && is_irq) return base + (XLEN'(code) << sh);
    return base;
  endfunction

  function automatic logic [1:0] legal_ppl(input logic [1:0] v);
    return (v == PRIV_MACH) ? PRIV_MACH : PRIV_USER;
  endfunction

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  acc_kind_e        acc_kind,
  input  logic             src_zero,
  input  logic [1:0]       priv,
  output logic             acc_bad,
  output logic             wr_en
);
  logic exists, wants_write, ro;

  always_comb begin
    exists      = (acc_idx < IDX_W'(NUM_CSR));
    wants_write = (acc_kind == KIND_WRITE) || !src_zero;
    ro          = is_read_only(acc_idx);
    acc_bad     = acc_valid && ((acc_kind == KIND_NONE) || !exists ||
                                (priv != PRIV_MACH) || (wants_write && ro));
    wr_en       = acc_valid && !acc_bad && wants_write;
  end

  // R4
  ro_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && is_read_only(acc_idx) && !src_zero) |-> !wr_en);

  // R5
  user_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && priv == PRIV_USER) |-> (acc_bad && !wr_en));
endmodule

// File: rtl/mcsr_irq_arb.sv
module mcsr_irq_arb
  import mcsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [XLEN-1:0]    ie,
  input  logic               gie,
  input  logic [1:0]         priv,
  output logic [XLEN-1:0]    pend_word,
  output logic               take,
  output logic [CODE_W-1:0]  cause
);
  logic [XLEN-1:0] armed;
  logic            gate_open;

  always_comb begin
    pend_word            = '0;
    pend_word[BIT_SOFT]  = irq_in[0];
    pend_word[BIT_TIMER] = irq_in[1];
    pend_word[BIT_EXT]   = irq_in[2];
    armed                = pend_word & ie;
    gate_open            = (priv == PRIV_USER) || gie;
    take                 = gate_open && (|armed);
    if (armed[BIT_EXT])        cause = CODE_W'(BIT_EXT);
    else if (armed[BIT_SOFT])  cause = CODE_W'(BIT_SOFT);
    else if (armed[BIT_TIMER]) cause = CODE_W'(BIT_TIMER);
    else                       cause = '0;
  end

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_in == '0) || ((pend_word & ie) == '0)) |-> !take);

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ie[cause] && pend_word[cause]));
endmodule

// File: rtl/mcsr_vector.sv
module mcsr_vector
  import mcsr_pkg::*;
#(
  parameter int unsigned STRIDE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [XLEN-1:0]   tvec,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   target
);
  always_comb target = vec_target(tvec, is_irq, code, STRIDE_LOG2);

  // R9
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (target[1:0] == 2'b00));

  // R9
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (!is_irq || tvec[1:0] != 2'b01)) |-> (target[XLEN-1:2] == tvec[XLEN-1:2]));
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
  import mcsr_pkg::*;
#(
  parameter logic [31:0] RESET_TVEC  = 32'h0000_0100,
  parameter logic [31:0] ISA_WORD    = 32'h4000_1100,
  parameter int unsigned STRIDE_LOG2 = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic [1:0]  acc_kind,
  input  logic [3:0]  acc_idx,
  input  logic        acc_use_imm,
  input  logic [31:0] acc_src,
  input  logic [4:0]  acc_uimm,
  output logic [31:0] acc_rdata,
  output logic        illegal,
  input  logic        trap_req,
  input  logic        trap_is_irq,
  input  logic [4:0]  trap_code,
  input  logic [31:0] trap_pc,
  input  logic [31:0] trap_tval,
  input  logic        ret_req,
  input  logic [2:0]  irq_in,
  output logic        irq_take,
  output logic [4:0]  irq_cause,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic [1:0]  priv_mode
);
  logic [1:0]      priv_q, ppl_q;
  logic            gie_q, pgie_q;
  logic [XLEN-1:0] ie_q, tvec_q, epc_q, cause_q, tval_q, scratch_q;

  logic [XLEN-1:0] status_word, pend_word, rd_word, src_word, new_val, trap_target;
  logic            acc_bad, wr_en;
  logic            trap_fire, ret_fire, ret_bad, csr_fire;
  acc_kind_e       kind;

  always_comb begin
    kind        = acc_kind_e'(acc_kind);
    src_word    = acc_use_imm ? XLEN'(acc_uimm) : acc_src;
    status_word = '0;
    status_word[BIT_GIE]           = gie_q;
    status_word[BIT_PGIE]          = pgie_q;
    status_word[BIT_PPL+1:BIT_PPL] = ppl_q;
  end

  mcsr_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_idx  (acc_idx),
    .acc_kind (kind),
    .src_zero (src_word == '0),
    .priv     (priv_q),
    .acc_bad  (acc_bad),
    .wr_en    (wr_en)
  );

  mcsr_irq_arb u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .ie       (ie_q),
    .gie      (gie_q),
    .priv     (priv_q),
    .pend_word(pend_word),
    .take     (irq_take),
    .cause    (irq_cause)
  );

  mcsr_vector #(.STRIDE_LOG2(STRIDE_LOG2)) u_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (trap_req),
    .tvec  (tvec_q),
    .is_irq(trap_is_irq),
    .code  (trap_code),
    .target(trap_target)
  );

  // read side
  always_comb begin
    case (acc_idx)
      IX_STATUS:  rd_word = status_word;
      IX_ISA:     rd_word = ISA_WORD;
      IX_IE:      rd_word = ie_q;
      IX_TVEC:    rd_word = tvec_q;
      IX_EPC:     rd_word = epc_q;
      IX_CAUSE:   rd_word = cause_q;
      IX_TVAL:    rd_word = tval_q;
      IX_IP:      rd_word = pend_word;
      IX_SCRATCH: rd_word = scratch_q;
      default:    rd_word = '0;
    endcase
    new_val = apply_op(kind, rd_word, src_word);
  end

  // event wires
  always_comb begin
    trap_fire      = trap_req;
    ret_fire       = ret_req && !trap_req && (priv_q == PRIV_MACH);
    ret_bad        = ret_req && !trap_req && (priv_q != PRIV_MACH);
    csr_fire       = wr_en && !trap_req && !ret_req;
    illegal        = acc_bad || ret_bad;
    redirect_valid = trap_fire || ret_fire;
    redirect_pc    = trap_fire ? trap_target : epc_q;
    acc_rdata      = rd_word;
    priv_mode      = priv_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q    <= PRIV_MACH;
      ppl_q     <= PRIV_USER;
      gie_q     <= 1'b0;
      pgie_q    <= 1'b0;
      ie_q      <= '0;
      tvec_q    <= RESET_TVEC;
      epc_q     <= '0;
      cause_q   <= '0;
      tval_q    <= '0;
      scratch_q <= '0;
    end else if (trap_fire) begin
      epc_q   <= {trap_pc[XLEN-1:2], 2'b00};
      cause_q <= {trap_is_irq, {(XLEN-1-CODE_W){1'b0}}, trap_code};
      tval_q  <= (!trap_is_irq && tval_kept(trap_code)) ? trap_tval : '0;
      pgie_q  <= gie_q;
      gie_q   <= 1'b0;
      ppl_q   <= priv_q;
      priv_q  <= PRIV_MACH;
    end else if (ret_fire) begin
      priv_q <= ppl_q;
      gie_q  <= pgie_q;
      pgie_q <= 1'b1;
      ppl_q  <= PRIV_USER;
    end else if (csr_fire) begin
      case (acc_idx)
        IX_STATUS: begin
          gie_q  <= new_val[BIT_GIE];
          pgie_q <= new_val[BIT_PGIE];
          ppl_q  <= legal_ppl(new_val[BIT_PPL+1:BIT_PPL]);
        end
        IX_IE:      ie_q      <= new_val & IE_MASK;
        IX_TVEC:    tvec_q    <= {new_val[XLEN-1:2], (new_val[1:0] == 2'b01) ? 2'b01 : 2'b00};
        IX_EPC:     epc_q     <= {new_val[XLEN-1:2], 2'b00};
        IX_CAUSE:   cause_q   <= new_val;
        IX_TVAL:    tval_q    <= new_val;
        IX_SCRATCH: scratch_q <= new_val;
        default: ;
      endcase
    end
  end

  // R7
  trap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (priv_q == PRIV_MACH && !gie_q && pgie_q == $past(gie_q) && ppl_q == $past(priv_q)));

  // R10
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (priv_q == $past(ppl_q) && gie_q == $past(pgie_q) && pgie_q && ppl_q == PRIV_USER));

  // R5
  user_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && priv_q == PRIV_USER && !trap_req && !ret_req) |=>
      ($stable(scratch_q) && $stable(tvec_q) && $stable(ie_q) && $stable(epc_q)));

  // R2
  id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_idx <= IX_IMPL || acc_idx == IX_STATUSH)) |-> (acc_rdata == '0));

  // R12
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> ($stable(scratch_q) && $stable(ie_q) && $stable(tvec_q)));

  // R10
  ret_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_bad |-> (!redirect_valid && illegal));
endmodule

// File: tb/sim_mcsr_trap_unit.sv
module sim_mcsr_trap_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n, acc_valid, acc_use_imm, illegal;
  logic [1:0]  acc_kind, priv_mode;
  logic [3:0]  acc_idx;
  logic [31:0] acc_src, acc_rdata, trap_pc, trap_tval, redirect_pc;
  logic [4:0]  acc_uimm, trap_code, irq_cause;
  logic        trap_req, trap_is_irq, ret_req, irq_take, redirect_valid;
  logic [2:0]  irq_in;

  mcsr_trap_unit u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic csr_cycle(input logic [1:0] k, input logic imm, input logic [3:0] ix,
                           input logic [31:0] d, output logic [31:0] rd, output logic ill);
    acc_valid = 1; acc_kind = k; acc_use_imm = imm; acc_idx = ix;
    acc_src = d; acc_uimm = d[4:0];
    #2;
    rd = acc_rdata; ill = illegal;
    @(posedge clk); @(negedge clk);
    acc_valid = 0; acc_kind = 2'b00; acc_use_imm = 0; acc_src = 0; acc_uimm = 0;
  endtask

  task automatic rd_csr(input logic [3:0] ix, output logic [31:0] rd);
    logic ill;
    csr_cycle(2'b10, 1'b0, ix, 32'h0, rd, ill);
  endtask

  task automatic trap_cycle(input logic irq, input logic [4:0] code, input logic [31:0] pc,
                            input logic [31:0] tv, output logic [31:0] tgt, output logic vld);
    trap_req = 1; trap_is_irq = irq; trap_code = code; trap_pc = pc; trap_tval = tv;
    #2;
    tgt = redirect_pc; vld = redirect_valid;
    @(posedge clk); @(negedge clk);
    trap_req = 0; trap_is_irq = 0; trap_code = 0; trap_pc = 0; trap_tval = 0;
  endtask

  // kind(2) imm(1) idx(4) data(32) expected old value(32)
  localparam int NV = 21;
  localparam logic [70:0] VEC [NV] = '{
    {2'b01, 1'b0, 4'd12, 32'hAAAA0000, 32'h00000000},
    {2'b10, 1'b0, 4'd12, 32'h0000FFFF, 32'hAAAA0000},
    {2'b11, 1'b1, 4'd12, 32'h0000000F, 32'hAAAAFFFF},
    {2'b10, 1'b0, 4'd12, 32'h00000000, 32'hAAAAFFF0},
    {2'b01, 1'b0, 4'd6,  32'h00001003, 32'h00000100},
    {2'b10, 1'b0, 4'd6,  32'h00000000, 32'h00001000},
    {2'b01, 1'b0, 4'd5,  32'hFFFFFFFF, 32'h00000000},
    {2'b10, 1'b0, 4'd5,  32'h00000000, 32'h00000888},
    {2'b01, 1'b0, 4'd3,  32'hFFFFFFFF, 32'h00000000},
    {2'b10, 1'b0, 4'd3,  32'h00000000, 32'h00001888},
    {2'b01, 1'b0, 4'd3,  32'h00001000, 32'h00001888},
    {2'b10, 1'b0, 4'd3,  32'h00000000, 32'h00000000},
    {2'b01, 1'b0, 4'd8,  32'h00000123, 32'h00000000},
    {2'b10, 1'b0, 4'd8,  32'h00000000, 32'h00000120},
    {2'b10, 1'b0, 4'd4,  32'h00000000, 32'h40001100},
    {2'b10, 1'b0, 4'd0,  32'h00000000, 32'h00000000},
    {2'b01, 1'b0, 4'd7,  32'hFFFFFFFF, 32'h00000000},
    {2'b10, 1'b0, 4'd7,  32'h00000000, 32'h00000000},
    {2'b10, 1'b1, 4'd9,  32'h00000000, 32'h00000000},
    {2'b01, 1'b1, 4'd10, 32'h0000001F, 32'h00000000},
    {2'b10, 1'b0, 4'd10, 32'h00000000, 32'h0000001F}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got %h expected %h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, tgt;
    logic ill, vld;
    rst_n = 0; acc_valid = 0; acc_kind = 0; acc_idx = 0; acc_use_imm = 0;
    acc_src = 0; acc_uimm = 0; trap_req = 0; trap_is_irq = 0; trap_code = 0;
    trap_pc = 0; trap_tval = 0; ret_req = 0; irq_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    chk("R1 level", {30'd0, priv_mode}, 32'h3);
    chk("R1 redirect", {31'd0, redirect_valid}, 32'h0);
    chk("R1 illegal", {31'd0, illegal}, 32'h0);
    chk("R1 take", {31'd0, irq_take}, 32'h0);
    rd_csr(4'd3, rd); chk("R1 status", rd, 32'h0);
    rd_csr(4'd6, rd); chk("R1 vector", rd, 32'h100);

    // R3 R6 R2 table walk
    for (int i = 0; i < NV; i++) begin
      csr_cycle(VEC[i][70:69], VEC[i][68], VEC[i][67:64], VEC[i][63:32], rd, ill);
      chk($sformatf("R3 R6 R2 vector %0d rdata", i), rd, VEC[i][31:0]);
      chk($sformatf("R3 vector %0d illegal", i), {31'd0, ill}, 32'h0);
    end

    // R4 read-only handling
    csr_cycle(2'b01, 1'b0, 4'd4, 32'h0, rd, ill);
    chk("R4 write isa illegal", {31'd0, ill}, 32'h1);
    rd_csr(4'd4, rd); chk("R4 isa unchanged", rd, 32'h40001100);
    csr_cycle(2'b11, 1'b1, 4'd11, 32'h0, rd, ill);
    chk("R4 zero clear legal", {31'd0, ill}, 32'h0);
    csr_cycle(2'b10, 1'b0, 4'd11, 32'h8, rd, ill);
    chk("R4 set pending illegal", {31'd0, ill}, 32'h1);
    csr_cycle(2'b10, 1'b0, 4'd13, 32'h0, rd, ill);
    chk("R2 index 13 illegal", {31'd0, ill}, 32'h1);
    csr_cycle(2'b00, 1'b0, 4'd12, 32'h0, rd, ill);
    chk("R3 kind 00 illegal", {31'd0, ill}, 32'h1);

    // R11 interrupts (status gie 0, ie 888)
    irq_in = 3'b111; #2;
    chk("R11 gated by gie", {31'd0, irq_take}, 32'h0);
    rd_csr(4'd11, rd); chk("R11 pending word", rd, 32'h888);
    csr_cycle(2'b01, 1'b0, 4'd3, 32'h8, rd, ill);
    #2;
    chk("R11 take", {31'd0, irq_take}, 32'h1);
    chk("R11 cause ext", {27'd0, irq_cause}, 32'd11);
    irq_in = 3'b011; #2;
    chk("R11 cause soft", {27'd0, irq_cause}, 32'd3);
    irq_in = 3'b010; #2;
    chk("R11 cause timer", {27'd0, irq_cause}, 32'd7);
    @(negedge clk);
    csr_cycle(2'b01, 1'b0, 4'd5, 32'h8, rd, ill);
    #2;
    chk("R11 masked", {31'd0, irq_take}, 32'h0);
    irq_in = 3'b000;
    @(negedge clk);

    // R9 R7 R8 vectored interrupt trap
    csr_cycle(2'b01, 1'b0, 4'd6, 32'h2001, rd, ill);
    trap_cycle(1'b1, 5'd7, 32'h400, 32'h55, tgt, vld);
    chk("R9 redirect valid", {31'd0, vld}, 32'h1);
    chk("R9 vectored target", tgt, 32'h201C);
    rd_csr(4'd3, rd); chk("R7 status after trap", rd, 32'h1880);
    rd_csr(4'd9, rd); chk("R7 cause irq", rd, 32'h80000007);
    rd_csr(4'd8, rd); chk("R7 return address", rd, 32'h400);
    rd_csr(4'd10, rd); chk("R8 tval cleared on irq", rd, 32'h0);

    // R8 R9 exception with fault address
    trap_cycle(1'b0, 5'd5, 32'h500, 32'hDEAD, tgt, vld);
    chk("R9 exception base", tgt, 32'h2000);
    rd_csr(4'd10, rd); chk("R8 tval captured", rd, 32'hDEAD);
    rd_csr(4'd9, rd); chk("R7 cause exc", rd, 32'h5);
    rd_csr(4'd3, rd); chk("R7 status nested", rd, 32'h1800);

    // R10 return to user
    csr_cycle(2'b01, 1'b0, 4'd3, 32'h80, rd, ill);
    ret_req = 1; #2;
    chk("R10 redirect valid", {31'd0, redirect_valid}, 32'h1);
    chk("R10 redirect target", redirect_pc, 32'h500);
    @(posedge clk); @(negedge clk); ret_req = 0;
    chk("R10 level user", {30'd0, priv_mode}, 32'h0);

    // R5 user access
    csr_cycle(2'b01, 1'b0, 4'd12, 32'h1234, rd, ill);
    chk("R5 user write illegal", {31'd0, ill}, 32'h1);
    ret_req = 1; #2;
    chk("R10 user return illegal", {31'd0, illegal}, 32'h1);
    chk("R10 user return no redirect", {31'd0, redirect_valid}, 32'h0);
    @(posedge clk); @(negedge clk); ret_req = 0;
    chk("R10 still user", {30'd0, priv_mode}, 32'h0);

    // R7 R8 trap from user
    trap_cycle(1'b0, 5'd2, 32'h600, 32'h77, tgt, vld);
    chk("R9 exception in vectored mode", tgt, 32'h2000);
    chk("R7 level machine", {30'd0, priv_mode}, 32'h3);
    rd_csr(4'd3, rd); chk("R7 status from user", rd, 32'h80);
    rd_csr(4'd10, rd); chk("R8 tval cleared code 2", rd, 32'h0);
    rd_csr(4'd12, rd); chk("R5 scratch untouched", rd, 32'hAAAAFFF0);

    // R12 simultaneous requests
    acc_valid = 1; acc_kind = 2'b01; acc_idx = 4'd12; acc_src = 32'h9999;
    ret_req = 1;
    trap_cycle(1'b0, 5'd3, 32'h700, 32'h0, tgt, vld);
    acc_valid = 0; acc_kind = 0; acc_src = 0; ret_req = 0;
    chk("R12 trap target wins", tgt, 32'h2000);
    rd_csr(4'd12, rd); chk("R12 write suppressed", rd, 32'hAAAAFFF0);
    rd_csr(4'd8, rd); chk("R12 return address from trap", rd, 32'h700);

    // R9 direct mode interrupt
    csr_cycle(2'b01, 1'b0, 4'd6, 32'h3002, rd, ill);
    trap_cycle(1'b1, 5'd11, 32'h800, 32'h0, tgt, vld);
    chk("R9 direct irq target", tgt, 32'h3000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule